// File: doc/BRIEF.md
# Sector Write Preamble Formatter

This block shapes the byte stream of one hard-sector write. A host raises a write gate and streams bytes one per valid strobe. The block first passes the host's gap bytes through unchanged. Once enough gap bytes have gone by, the host marks the start of the preamble with a nonzero byte. From that byte on, the block replaces what the host sends with a fixed preamble: five training bytes of 93h and then a single sync byte of 69h. It passes the user data through directly after the sync byte. Every output byte carries a tag that names its field.

After the last user byte, the block holds a busy flag for a flush window. The host must keep the write gate high for that window. The window is 16 cycles when the data interface runs byte-wide and 21 cycles when it runs nibble-wide. If the gate drops while the block is busy, the sector is abandoned. In that case the block raises a sticky error, silences its output and ignores all input until reset.

Top module: `secwr_fmt`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, outValid, outByte, outField, busy and errFlag are all zero.
- R2: A byte is accepted on a rising edge where writeGate and inValid are both high. During the gap field, each accepted byte appears unchanged on outByte with outField = 0 and outValid high, in the cycle after that edge.
- R3: The training field starts at the first accepted nonzero byte that arrives once at least 8 gap bytes have been accepted since writeGate went high. A nonzero byte that arrives earlier stays a gap byte.
- R4: The byte that starts training and the next four accepted bytes are each emitted as 93h with outField = 1, whatever value the host presents.
- R5: The accepted byte right after the fifth training byte is emitted as 69h with outField = 2. There is exactly one such byte per sector.
- R6: dataLen is sampled on the edge where writeGate is first seen high. The dataLen accepted bytes that follow the sync byte are emitted unchanged with outField = 3. When dataLen is 0, the block goes from sync straight to the flush window.
- R7: On a cycle with no accepted byte, outValid is low on the next cycle and the field sequence does not advance.
- R8: busy goes high in the cycle after writeGate is first seen high. It stays high for 16 cycles after the edge that accepts the last data byte when nibbleMode = 0, or 21 cycles when nibbleMode = 1, and then goes low.
- R9: After the flush window, accepted bytes produce no output until writeGate is sampled low. A later rise of writeGate starts a new sector.
- R10: If writeGate is sampled low while busy is high, errFlag goes high and stays high until reset. From then on, outValid and busy stay low and all inputs are ignored.
- R11: Whenever outValid is low, outByte is 00h and outField is 0. The field codes are gap 0, training 1, sync 2 and data 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| writeGate | input | 1 | Write gate from the host |
| inValid | input | 1 | Host byte strobe |
| inByte | input | 8 | Host byte |
| dataLen | input | 8 | Number of user data bytes in the sector |
| nibbleMode | input | 1 | Selects the 21-cycle flush window when high, the 16-cycle window when low |
| outValid | output | 1 | Output byte valid |
| outByte | output | 8 | Formatted byte |
| outField | output | 2 | Field tag of outByte |
| busy | output | 1 | Sector in progress, including the flush window |
| errFlag | output | 1 | Sticky error: write gate dropped while busy |

## Verification
A behavioural model in the bench runs alongside the design and is compared with it every cycle. The sectors it drives separate the different cases:
- A sector with an all-zero gap and an idle strobe inside it shows that the byte count, not the cycle count, governs the gap.
- A sector with a nonzero byte before the eighth gap byte, and arbitrary training values, tells early marks apart from real preamble starts and shows that the replacement is unconditional.
- Byte-wide and nibble-wide sectors, each with trailing bytes sent after the flush, separate the two flush lengths and check that late input is ignored.
- Gate drops inside the gap and inside the flush window, a zero-length sector, and a sector with pseudo-random strobe gaps cover the error path and the sequencing.

// File: rtl/secwr_pkg.sv
package secwr_pkg;

  typedef enum logic [1:0] {
    TAG_GAP   = 2'd0,
    TAG_TRAIN = 2'd1,
    TAG_SYNC  = 2'd2,
    TAG_DATA  = 2'd3
  } fieldTag_e;

  // Per-cycle command from control to datapath
  typedef struct packed {
    logic      emit;
    fieldTag_e tag;
  } fmtStrobe_t;

endpackage

// File: rtl/secwr_ctrl.sv
module secwr_ctrl
  import secwr_pkg::*;
#(
  parameter int BYTE_W         = 8,
  parameter int LEN_W          = 8,
  parameter int MIN_GAP        = 8,
  parameter int TRAIN_LEN      = 5,
  parameter int FLUSH_BYTE_CYC = 16,
  parameter int FLUSH_NIB_CYC  = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              writeGate,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inByte,
  input  logic [LEN_W-1:0]  dataLen,
  input  logic              nibbleMode,
  output fmtStrobe_t        strobe,
  output logic              busy,
  output logic              errFlag
);

  localparam int GAP_W  = $clog2(MIN_GAP + 1);
  localparam int TR_W   = $clog2(TRAIN_LEN);
  localparam int FL_MAX = (FLUSH_NIB_CYC > FLUSH_BYTE_CYC) ? FLUSH_NIB_CYC : FLUSH_BYTE_CYC;
  localparam int FL_W   = $clog2(FL_MAX + 1);

  localparam logic [GAP_W-1:0] GAP_MIN_V = GAP_W'(MIN_GAP);
  localparam logic [GAP_W-1:0] GAP_ONE   = GAP_W'(1);
  localparam logic [TR_W-1:0]  TR_LAST_V = TR_W'(TRAIN_LEN - 1);
  localparam logic [TR_W-1:0]  TR_ONE    = TR_W'(1);
  localparam logic [LEN_W-1:0] LEN_ONE   = LEN_W'(1);
  localparam logic [FL_W-1:0]  FL_BYTE_V = FL_W'(FLUSH_BYTE_CYC);
  localparam logic [FL_W-1:0]  FL_NIB_V  = FL_W'(FLUSH_NIB_CYC);
  localparam logic [FL_W-1:0]  FL_ONE    = FL_W'(1);

  typedef enum logic [2:0] {
    PH_IDLE, PH_GAP, PH_TRAIN, PH_SYNC, PH_DATA, PH_FLUSH, PH_DONE, PH_HALT
  } phase_e;

  phase_e            phase, phaseNxt;
  logic [GAP_W-1:0]  gapCnt;
  logic [TR_W-1:0]   trainCnt;
  logic [LEN_W-1:0]  dataCnt, lenReg;
  logic [FL_W-1:0]   flushCnt, flushLim;
  logic              nibReg;

  logic gapFull, trainLast, dataLast, flushLast, markByte;

  assign gapFull   = (gapCnt == GAP_MIN_V);
  assign trainLast = (trainCnt == TR_LAST_V);
  assign dataLast  = (({1'b0, dataCnt} + {1'b0, LEN_ONE}) == {1'b0, lenReg});
  assign flushLim  = nibReg ? FL_NIB_V : FL_BYTE_V;
  assign flushLast = (flushCnt == (flushLim - FL_ONE));
  assign markByte  = (inByte != '0);

  always_comb begin
    phaseNxt    = phase;
    strobe.emit = 1'b0;
    strobe.tag  = TAG_GAP;
    unique case (phase)
      PH_IDLE: if (writeGate) begin
        phaseNxt    = PH_GAP;
        strobe.emit = inValid;
      end
      PH_GAP: if (!writeGate) phaseNxt = PH_HALT;
      else if (inValid) begin
        strobe.emit = 1'b1;
        if (markByte && gapFull) begin
          strobe.tag = TAG_TRAIN;
          phaseNxt   = PH_TRAIN;
        end
      end
      PH_TRAIN: if (!writeGate) phaseNxt = PH_HALT;
      else if (inValid) begin
        strobe.emit = 1'b1;
        strobe.tag  = TAG_TRAIN;
        if (trainLast) phaseNxt = PH_SYNC;
      end
      PH_SYNC: if (!writeGate) phaseNxt = PH_HALT;
      else if (inValid) begin
        strobe.emit = 1'b1;
        strobe.tag  = TAG_SYNC;
        phaseNxt    = (lenReg == '0) ? PH_FLUSH : PH_DATA;
      end
      PH_DATA: if (!writeGate) phaseNxt = PH_HALT;
      else if (inValid) begin
        strobe.emit = 1'b1;
        strobe.tag  = TAG_DATA;
        if (dataLast) phaseNxt = PH_FLUSH;
      end
      PH_FLUSH: if (!writeGate) phaseNxt = PH_HALT;
      else if (flushLast) phaseNxt = PH_DONE;
      PH_DONE: if (!writeGate) phaseNxt = PH_IDLE;
      PH_HALT: phaseNxt = PH_HALT;
      default: phaseNxt = PH_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      gapCnt   <= '0;
      trainCnt <= '0;
      dataCnt  <= '0;
      lenReg   <= '0;
      nibReg   <= 1'b0;
      flushCnt <= '0;
    end else begin
      phase <= phaseNxt;
      if (phase == PH_IDLE) begin
        lenReg <= dataLen;
        nibReg <= nibbleMode;
        gapCnt <= (writeGate && inValid) ? GAP_ONE : '0;
      end else if (phase == PH_GAP && strobe.emit && strobe.tag == TAG_GAP && !gapFull) begin
        gapCnt <= gapCnt + GAP_ONE;
      end
      if (phase == PH_GAP) trainCnt <= TR_ONE;
      else if (phase == PH_TRAIN && strobe.emit) trainCnt <= trainCnt + TR_ONE;
      if (phase == PH_SYNC) dataCnt <= '0;
      else if (phase == PH_DATA && strobe.emit) dataCnt <= dataCnt + LEN_ONE;
      if (phase == PH_FLUSH) flushCnt <= flushCnt + FL_ONE;
      else flushCnt <= '0;
    end
  end

  assign busy    = (phase inside {PH_GAP, PH_TRAIN, PH_SYNC, PH_DATA, PH_FLUSH});
  assign errFlag = (phase == PH_HALT);

endmodule

// File: rtl/secwr_dpath.sv
module secwr_dpath
  import secwr_pkg::*;
#(
  parameter int                BYTE_W     = 8,
  parameter logic [BYTE_W-1:0] TRAIN_BYTE = 8'h93,
  parameter logic [BYTE_W-1:0] SYNC_BYTE  = 8'h69
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fmtStrobe_t        strobe,
  input  logic [BYTE_W-1:0] inByte,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte,
  output logic [1:0]        outField
);

  logic [BYTE_W-1:0] pick;

  always_comb begin
    unique case (strobe.tag)
      TAG_TRAIN: pick = TRAIN_BYTE;
      TAG_SYNC:  pick = SYNC_BYTE;
      default:   pick = inByte;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outByte  <= '0;
      outField <= 2'd0;
    end else begin
      outValid <= strobe.emit;
      outByte  <= strobe.emit ? pick : '0;
      outField <= strobe.emit ? strobe.tag : 2'd0;
    end
  end

endmodule

// File: rtl/secwr_fmt.sv
module secwr_fmt
  import secwr_pkg::*;
#(
  parameter int                BYTE_W         = 8,
  parameter int                LEN_W          = 8,
  parameter int                MIN_GAP        = 8,
  parameter int                TRAIN_LEN      = 5,
  parameter int                FLUSH_BYTE_CYC = 16,
  parameter int                FLUSH_NIB_CYC  = 21,
  parameter logic [BYTE_W-1:0] TRAIN_BYTE     = 8'h93,
  parameter logic [BYTE_W-1:0] SYNC_BYTE      = 8'h69
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              writeGate,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inByte,
  input  logic [LEN_W-1:0]  dataLen,
  input  logic              nibbleMode,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte,
  output logic [1:0]        outField,
  output logic              busy,
  output logic              errFlag
);

  fmtStrobe_t strobe;

  secwr_ctrl #(
    .BYTE_W(BYTE_W), .LEN_W(LEN_W), .MIN_GAP(MIN_GAP), .TRAIN_LEN(TRAIN_LEN),
    .FLUSH_BYTE_CYC(FLUSH_BYTE_CYC), .FLUSH_NIB_CYC(FLUSH_NIB_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .writeGate(writeGate), .inValid(inValid),
    .inByte(inByte), .dataLen(dataLen), .nibbleMode(nibbleMode),
    .strobe(strobe), .busy(busy), .errFlag(errFlag)
  );

  secwr_dpath #(
    .BYTE_W(BYTE_W), .TRAIN_BYTE(TRAIN_BYTE), .SYNC_BYTE(SYNC_BYTE)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .inByte(inByte),
    .outValid(outValid), .outByte(outByte), .outField(outField)
  );

endmodule

// File: rtl/secwr_fmt_chk.sv
module secwr_fmt_chk #(
  parameter int                BYTE_W     = 8,
  parameter logic [BYTE_W-1:0] TRAIN_BYTE = 8'h93,
  parameter logic [BYTE_W-1:0] SYNC_BYTE  = 8'h69
) (
  input logic              clk,
  input logic              rst_n,
  input logic              writeGate,
  input logic              inValid,
  input logic              outValid,
  input logic [BYTE_W-1:0] outByte,
  input logic [1:0]        outField,
  input logic              busy,
  input logic              errFlag
);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> (outByte == '0 && outField == 2'd0));

  p_train_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outField == 2'd1) |-> outByte == TRAIN_BYTE);

  p_sync_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outField == 2'd2) |-> outByte == SYNC_BYTE);

  p_emit_needs_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $past(writeGate && inValid));

  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    errFlag |=> errFlag);

  p_halt_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    errFlag |-> (!outValid && !busy));

  p_gate_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !writeGate) |=> errFlag);

  p_data_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outField == 2'd3) |=> (!outValid || outField == 2'd3));

endmodule

bind secwr_fmt secwr_fmt_chk #(
  .BYTE_W(BYTE_W), .TRAIN_BYTE(TRAIN_BYTE), .SYNC_BYTE(SYNC_BYTE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .writeGate(writeGate), .inValid(inValid),
  .outValid(outValid), .outByte(outByte), .outField(outField),
  .busy(busy), .errFlag(errFlag)
);

// File: tb/sim_secwr_fmt.sv
`timescale 1ns/1ps
module sim_secwr_fmt;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       writeGate = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic [7:0] dataLen = 8'h00;
  logic       nibbleMode = 1'b0;
  logic       outValid, busy, errFlag;
  logic [7:0] outByte;
  logic [1:0] outField;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  secwr_fmt u0 (
    .clk(clk), .rst_n(rst_n), .writeGate(writeGate), .inValid(inValid),
    .inByte(inByte), .dataLen(dataLen), .nibbleMode(nibbleMode),
    .outValid(outValid), .outByte(outByte), .outField(outField),
    .busy(busy), .errFlag(errFlag)
  );

  // Behavioural reference: phase 0 idle,1 gap,2 train,3 sync,4 data,5 flush,6 done,7 halted
  int mPhase = 0, gapSeen = 0, trainLeft = 0, dataLeft = 0, flushLeft = 0, mLen = 0;
  bit mNib = 0;
  bit eValid = 0;
  int eByte = 0, eTag = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mPhase = 0; gapSeen = 0; eValid = 0; eByte = 0; eTag = 0;
    end else begin
      eValid = 0; eByte = 0; eTag = 0;
      case (mPhase)
        0: begin
          mLen = dataLen; mNib = nibbleMode;
          if (writeGate) begin
            mPhase = 1; gapSeen = 0;
            if (inValid) begin eValid = 1; eByte = inByte; gapSeen = 1; end
          end
        end
        1: if (!writeGate) mPhase = 7;
           else if (inValid) begin
             eValid = 1;
             if (inByte != 0 && gapSeen >= 8) begin
               eByte = 8'h93; eTag = 1; trainLeft = 4; mPhase = 2;
             end else begin
               eByte = inByte; gapSeen++;
             end
           end
        2: if (!writeGate) mPhase = 7;
           else if (inValid) begin
             eValid = 1; eByte = 8'h93; eTag = 1; trainLeft--;
             if (trainLeft == 0) mPhase = 3;
           end
        3: if (!writeGate) mPhase = 7;
           else if (inValid) begin
             eValid = 1; eByte = 8'h69; eTag = 2;
             if (mLen == 0) begin mPhase = 5; flushLeft = mNib ? 21 : 16; end
             else begin mPhase = 4; dataLeft = mLen; end
           end
        4: if (!writeGate) mPhase = 7;
           else if (inValid) begin
             eValid = 1; eByte = inByte; eTag = 3; dataLeft--;
             if (dataLeft == 0) begin mPhase = 5; flushLeft = mNib ? 21 : 16; end
           end
        5: if (!writeGate) mPhase = 7;
           else begin flushLeft--; if (flushLeft == 0) mPhase = 6; end
        6: if (!writeGate) mPhase = 0;
        default: mPhase = 7;
      endcase
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R7", "outValid", outValid, eValid);
      case (eTag)
        1: check("R4", "outByte", outByte, eByte);
        2: check("R5", "outByte", outByte, eByte);
        3: check("R6", "outByte", outByte, eByte);
        default: check(eValid ? "R2" : "R11", "outByte", outByte, eByte);
      endcase
      check("R11", "outField", outField, eTag);
      check("R8", "busy", busy, (mPhase >= 1 && mPhase <= 5) ? 1 : 0);
      check("R10", "errFlag", errFlag, (mPhase == 7) ? 1 : 0);
    end
  end

  task automatic step(input bit wg, input bit iv, input logic [7:0] b);
    @(posedge clk); #2;
    writeGate = wg; inValid = iv; inByte = b;
  endtask

  task automatic doReset();
    @(posedge clk); #2;
    rst_n = 0; writeGate = 0; inValid = 0; inByte = 0;
    repeat (2) @(posedge clk);
    #1;
    check("R1", "outValid in reset", outValid, 0);
    check("R1", "busy in reset", busy, 0);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1", "errFlag after reset", errFlag, 0);
    check("R1", "outByte after reset", outByte, 0);
  endtask

  task automatic gapBytes(input int n);
    for (int i = 0; i < n; i++) step(1, 1, 8'h00);
  endtask

  task automatic dataBytes(input int n, input int seed);
    for (int i = 0; i < n; i++) step(1, 1, 8'(seed + i * 37));
  endtask

  task automatic countFlush(input string req, input int exp);
    int seen = 0;
    for (int i = 0; i < 30; i++) begin
      step(1, 1, 8'hC3); // R9: late bytes must stay invisible
      @(negedge clk);
      if (busy) seen++;
    end
    check(req, "flush cycles", seen, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr = 8'hA5;
    doReset();

    // Byte-wide sector, idle strobe inside the gap (R2, R7, R8, R9)
    dataLen = 8'd4; nibbleMode = 0;
    step(1, 0, 8'h00);
    gapBytes(3);
    step(1, 0, 8'h77);
    gapBytes(6);
    for (int i = 0; i < 6; i++) step(1, 1, 8'hFF);
    dataBytes(4, 8'h10);
    countFlush("R8", 16);
    step(0, 0, 8'h00);
    step(0, 0, 8'h00);
    @(negedge clk);
    check("R9", "errFlag after clean end", errFlag, 0);
    check("R11", "idle outByte", outByte, 0);

    // Nibble sector: early nonzero mark stays gap (R3), host training values ignored (R4)
    dataLen = 8'd2; nibbleMode = 1;
    step(1, 0, 8'h00);
    gapBytes(3);
    step(1, 1, 8'h5A);
    step(1, 1, 8'h00);
    @(negedge clk);
    check("R3", "early mark tag", outField, 0);
    check("R3", "early mark byte", outByte, 8'h5A);
    gapBytes(3);
    step(1, 1, 8'hAA);
    step(1, 1, 8'h11);
    @(negedge clk);
    check("R4", "training replaces host byte", outByte, 8'h93);
    step(1, 1, 8'h11); step(1, 1, 8'h11); step(1, 1, 8'h11);
    step(1, 1, 8'h22);
    step(1, 1, 8'hE1);
    @(negedge clk);
    check("R5", "sync tag", outField, 2);
    step(1, 1, 8'hE2);
    @(negedge clk);
    check("R6", "first data follows sync", outByte, 8'hE1);
    countFlush("R8", 21);
    step(0, 0, 8'h00);

    // Boundary: seventh-gap then mark is still gap (R3)
    dataLen = 8'd1; nibbleMode = 0;
    step(1, 0, 8'h00);
    gapBytes(7);
    step(1, 1, 8'hFF);
    for (int i = 0; i < 6; i++) step(1, 1, 8'hFF);
    dataBytes(1, 8'h3C);
    countFlush("R8", 16);
    step(0, 0, 8'h00);

    // Zero-length sector, gate dropped inside flush (R6, R10)
    dataLen = 8'd0;
    step(1, 0, 8'h00);
    gapBytes(8);
    for (int i = 0; i < 6; i++) step(1, 1, 8'hFF);
    for (int i = 0; i < 5; i++) step(1, 0, 8'h00);
    step(0, 0, 8'h00);
    step(1, 1, 8'h44);
    @(negedge clk);
    check("R10", "error after flush drop", errFlag, 1);
    check("R10", "busy cleared by error", busy, 0);
    step(1, 1, 8'h45);
    step(1, 1, 8'h46);
    @(negedge clk);
    check("R10", "input ignored after error", outValid, 0);
    doReset();

    // Gate dropped inside gap (R10)
    step(1, 0, 8'h00);
    gapBytes(4);
    step(0, 0, 8'h00);
    step(0, 0, 8'h00);
    @(negedge clk);
    check("R10", "error after gap drop", errFlag, 1);
    doReset();

    // Strobe gaps throughout a longer sector (R7)
    dataLen = 8'd20; nibbleMode = 1;
    step(1, 0, 8'h00);
    for (int n = 0; n < 200; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(1, lfsr[0] | lfsr[2], (n < 12) ? 8'h00 : lfsr);
    end
    step(0, 0, 8'h00);
    step(0, 0, 8'h00);
    @(negedge clk);
    check("R9", "no error after long sector", errFlag, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule